// File: doc/BRIEF.md
# DAC Sample FIFO Sequencer

This block sits in front of a digital-to-analog converter and decides which sample the converter sees. Software writes samples through a small four-word register port. Each trigger moves a read pointer through a power-of-two sample store. The entry under that pointer is the value driven on the sample output. A trigger comes either from a hardware input or from a self-clearing software bit.

There are three playback modes. Bypass holds a single sample that every data write replaces at once. Normal mode plays the stored samples in order, one per trigger. Swing mode sweeps the read pointer forward to the nearly-empty point, then back to the full point, over and over. Two sticky error flags (overflow and underflow) and three level flags (watermark, nearly empty, full) can raise a request. Each has an enable. The request goes either to the interrupt line or to the DMA request line.

Register map (word address on `reg_addr`):
- 0, control: bit 0 converter enable; bits 2:1 mode (0 bypass, 1 normal, 2 swing, 3 treated as bypass); bit 3 trigger source (0 hardware, 1 software); bit 4 software trigger (self-clearing, reads 0); bit 5 pointer reset command (reads 0); bit 6 software reset (reads 0); bit 7 DMA steering; bit 8 error enable; bit 9 watermark enable; bit 10 nearly-empty enable; bit 11 full enable; bits 24:16 watermark.
- 1, status: bit 0 overflow; bit 1 underflow (both write-1-to-clear); bit 2 watermark; bit 3 nearly empty; bit 4 full.
- 2, data: a write pushes the low DW bits.
- 3, pointers (read only): read index in bits 7:0, write index in bits 23:16.

Top module: `dac_fifo_seq`

## Requirements
- R1: After reset the control word, status word, pointer word, sample output, interrupt and DMA request all read 0.
- R2: In bypass mode, a data write appears on the sample output with no trigger, and the pointer word does not change.
- R3: In normal mode, a data write stores the sample at the write index and advances the write pointer. Each accepted trigger advances the read pointer. The sample output shows the stored entry at the read index.
- R4: A data write in normal or swing mode while the store holds DEPTH entries is dropped, leaves the pointers unchanged and sets the overflow flag (status bit 0).
- R5: In normal mode, a trigger accepted while one or zero entries remain sets the underflow flag (status bit 1) and leaves the read pointer unchanged.
- R6: The level flags follow the occupancy (write pointer minus read pointer). Nearly empty (bit 3) means exactly one entry. Watermark (bit 2) means occupancy below the watermark field. Full (bit 4) means DEPTH entries.
- R7: In swing mode, starting from a full store, triggers step the read index forward until one entry remains, then backward until the store is full again, and repeat with no underflow.
- R8: A control write with bit 5 set puts both pointers at 0 only when the stored converter enable is 0. Otherwise the pointers are unchanged.
- R9: A trigger has an effect only with the converter enabled and the mode normal or swing. Source 0 uses only the hardware input and source 1 only the software bit.
- R10: A hardware trigger acts on a rising edge only, so a level held high for many cycles advances the read pointer once.
- R11: The request is the OR of (enable bit 8 and either error flag), (bit 9 and watermark), (bit 10 and nearly empty) and (bit 11 and full). With bit 7 clear it drives the interrupt output, and with bit 7 set it drives the DMA request output while the interrupt output stays 0.
- R12: A control write with bit 6 set returns control, flags, pointers and sample output to their reset values.
- R13: Writing 1 to status bits 0 and 1 clears those flags only. Writing other status bits, or any control bit, leaves every flag as it was. An error event in the same cycle as its clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| hw_trig | input | 1 | Asynchronous hardware trigger |
| sample_out | output | DW | Sample driven to the converter |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
An underflow raised by a hardware trigger can land in the same cycle as a software write-1 clear of the underflow flag. The bench counts the synchroniser stages to place the status write on exactly the clock edge where the edge-detected trigger reaches the sequencer. The occupancy is one at that moment, so the trigger must underflow. The design passes only if the underflow flag still reads set afterwards and the read pointer has not moved.

// File: rtl/dac_fifo_pkg.sv
package dac_fifo_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
  localparam logic [1:0] ADDR_PTR  = 2'd3;
  localparam int WM_W = 9;

  localparam int B_EN     = 0;
  localparam int B_MODE   = 1;
  localparam int B_TSEL   = 3;
  localparam int B_SWTRG  = 4;
  localparam int B_FRST   = 5;
  localparam int B_SRST   = 6;
  localparam int B_DMA    = 7;
  localparam int B_IE     = 8;
  localparam int B_WM     = 16;

  typedef enum logic [1:0] {
    MODE_BYPASS = 2'd0,
    MODE_NORMAL = 2'd1,
    MODE_SWING  = 2'd2,
    MODE_RSVD   = 2'd3
  } fifo_mode_e;

  typedef struct packed {
    logic [WM_W-1:0] wm;
    logic [3:0]      ie;
    logic            dma_en;
    logic            trig_sw;
    fifo_mode_e      mode;
    logic            conv_en;
  } ctrl_t;
endpackage

// File: rtl/dac_fifo_regs.sv
module dac_fifo_regs
  import dac_fifo_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output ctrl_t       ctrl,
  output logic        sw_trig_pend,
  output logic        fifo_rst_cmd,
  output logic        soft_rst_cmd,
  output logic        data_push,
  output logic        clr_ovf,
  output logic        clr_udf
);
  ctrl_t ctrl_q, ctrl_d;
  logic  swp_q, swp_d;
  logic  ctrl_we, stat_we;
  logic  unused_wdata;

  assign ctrl_we      = reg_we && (reg_addr == ADDR_CTRL);
  assign stat_we      = reg_we && (reg_addr == ADDR_STAT);
  assign data_push    = reg_we && (reg_addr == ADDR_DATA);
  assign soft_rst_cmd = ctrl_we && reg_wdata[B_SRST];
  assign fifo_rst_cmd = ctrl_we && reg_wdata[B_FRST] && !ctrl_q.conv_en && !soft_rst_cmd;
  assign clr_ovf      = stat_we && reg_wdata[0];
  assign clr_udf      = stat_we && reg_wdata[1];
  assign unused_wdata = ^{reg_wdata[31:25], reg_wdata[15:12]};

  always_comb begin
    ctrl_d = ctrl_q;
    swp_d  = 1'b0;
    if (soft_rst_cmd) begin
      ctrl_d = '0;
    end else if (ctrl_we) begin
      ctrl_d.conv_en = reg_wdata[B_EN];
      ctrl_d.mode    = fifo_mode_e'(reg_wdata[B_MODE +: 2]);
      ctrl_d.trig_sw = reg_wdata[B_TSEL];
      ctrl_d.dma_en  = reg_wdata[B_DMA];
      ctrl_d.ie      = reg_wdata[B_IE +: 4];
      ctrl_d.wm      = reg_wdata[B_WM +: WM_W];
      swp_d          = reg_wdata[B_SWTRG];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      swp_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      swp_q  <= swp_d;
    end
  end

  assign ctrl         = ctrl_q;
  assign sw_trig_pend = swp_q;
endmodule

// File: rtl/dac_trig_sync.sv
module dac_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic trig_async,
  output logic trig_rise
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], trig_async};
    prev_d = sync_q[STAGES-1];
    if (clr) begin
      sync_d = '0;
      prev_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign trig_rise = sync_q[STAGES-1] && !prev_q;
endmodule

// File: rtl/dac_fifo_core.sv
module dac_fifo_core
  import dac_fifo_pkg::*;
#(
  parameter int DEPTH_CODE = 2,
  parameter int DW         = 12,
  localparam int AW        = DEPTH_CODE + 1,
  localparam int DEPTH     = 1 << AW,
  localparam int PW        = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ptr_clr,
  input  fifo_mode_e    mode,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          trig,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic [PW-1:0] occupancy,
  output logic [DW-1:0] sample,
  output logic          ovf_evt,
  output logic          udf_evt
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic          dir_q, dir_d;
  logic [DW-1:0] out_q, out_d;
  logic          mem_we, is_fifo, full, low, swing_back;

  assign occupancy  = wr_q - rd_q;
  assign full       = (occupancy == PW'(DEPTH));
  assign low        = (occupancy <= PW'(1));
  assign is_fifo    = (mode == MODE_NORMAL) || (mode == MODE_SWING);
  assign swing_back = (mode == MODE_SWING) && dir_q && !full;

  always_comb begin
    wr_d    = wr_q;
    rd_d    = rd_q;
    dir_d   = dir_q;
    mem_we  = 1'b0;
    ovf_evt = 1'b0;
    udf_evt = 1'b0;
    if (is_fifo && push) begin
      if (full) begin
        ovf_evt = 1'b1;
      end else begin
        mem_we = 1'b1;
        wr_d   = wr_q + PW'(1);
      end
    end
    if (is_fifo && trig) begin
      if (swing_back) begin
        rd_d = rd_q - PW'(1);
        if (occupancy == PW'(DEPTH - 1)) dir_d = 1'b0;
      end else if (low) begin
        udf_evt = 1'b1;
      end else begin
        rd_d = rd_q + PW'(1);
        if (mode == MODE_SWING) dir_d = (occupancy == PW'(2));
      end
    end
    if (clr || ptr_clr) begin
      wr_d  = '0;
      rd_d  = '0;
      dir_d = 1'b0;
    end
  end

  always_comb begin
    out_d = out_q;
    if (!is_fifo && push) out_d = push_data;
    else if (is_fifo && (occupancy != '0)) out_d = mem[rd_q[AW-1:0]];
    if (clr) out_d = '0;
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[wr_q[AW-1:0]] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      dir_q <= 1'b0;
      out_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      dir_q <= dir_d;
      out_q <= out_d;
    end
  end

  assign wr_ptr = wr_q;
  assign rd_ptr = rd_q;
  assign sample = out_q;
endmodule

// File: rtl/dac_fifo_status.sv
module dac_fifo_status
  import dac_fifo_pkg::*;
#(
  parameter int PW    = 4,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            ovf_evt,
  input  logic            udf_evt,
  input  logic            clr_ovf,
  input  logic            clr_udf,
  input  logic [PW-1:0]   occupancy,
  input  logic [WM_W-1:0] wm,
  input  logic [3:0]      ie,
  input  logic            dma_en,
  output logic            ovf_f,
  output logic            udf_f,
  output logic            wm_f,
  output logic            ne_f,
  output logic            full_f,
  output logic            irq,
  output logic            dma_req
);
  logic ovf_q, ovf_d, udf_q, udf_d, req;

  always_comb begin
    ovf_d = ovf_evt || (ovf_q && !clr_ovf);
    udf_d = udf_evt || (udf_q && !clr_udf);
    if (clr) begin
      ovf_d = 1'b0;
      udf_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      udf_q <= udf_d;
    end
  end

  assign ovf_f   = ovf_q;
  assign udf_f   = udf_q;
  assign wm_f    = (WM_W'(occupancy) < wm);
  assign ne_f    = (occupancy == PW'(1));
  assign full_f  = (occupancy == PW'(DEPTH));
  assign req     = (ie[0] && (ovf_q || udf_q)) || (ie[1] && wm_f) ||
                   (ie[2] && ne_f) || (ie[3] && full_f);
  assign irq     = req && !dma_en;
  assign dma_req = req && dma_en;
endmodule

// File: rtl/dac_fifo_seq.sv
module dac_fifo_seq
  import dac_fifo_pkg::*;
#(
  parameter int DEPTH_CODE = 2,
  parameter int DW         = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          hw_trig,
  output logic [DW-1:0] sample_out,
  output logic          irq,
  output logic          dma_req
);
  localparam int AW    = DEPTH_CODE + 1;
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  ctrl_t         ctrl;
  logic          sw_pend, fifo_rst_cmd, soft_rst_cmd, data_push, clr_ovf, clr_udf;
  logic          hw_rise, trig_eff, is_fifo;
  logic [PW-1:0] wr_ptr, rd_ptr, occupancy;
  logic          ovf_evt, udf_evt, ovf_f, udf_f, wm_f, ne_f, full_f;
  logic [31:0]   ctrl_word, stat_word, ptr_word;
  logic          unused_ptr;

  dac_fifo_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ctrl(ctrl), .sw_trig_pend(sw_pend),
    .fifo_rst_cmd(fifo_rst_cmd), .soft_rst_cmd(soft_rst_cmd),
    .data_push(data_push), .clr_ovf(clr_ovf), .clr_udf(clr_udf)
  );

  dac_trig_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst_cmd),
    .trig_async(hw_trig), .trig_rise(hw_rise)
  );

  assign is_fifo  = (ctrl.mode == MODE_NORMAL) || (ctrl.mode == MODE_SWING);
  assign trig_eff = ctrl.conv_en && is_fifo && (ctrl.trig_sw ? sw_pend : hw_rise);

  dac_fifo_core #(.DEPTH_CODE(DEPTH_CODE), .DW(DW)) u_core (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst_cmd), .ptr_clr(fifo_rst_cmd),
    .mode(ctrl.mode), .push(data_push), .push_data(reg_wdata[DW-1:0]),
    .trig(trig_eff), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .occupancy(occupancy),
    .sample(sample_out), .ovf_evt(ovf_evt), .udf_evt(udf_evt)
  );

  dac_fifo_status #(.PW(PW), .DEPTH(DEPTH)) u_stat (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst_cmd), .ovf_evt(ovf_evt),
    .udf_evt(udf_evt), .clr_ovf(clr_ovf), .clr_udf(clr_udf),
    .occupancy(occupancy), .wm(ctrl.wm), .ie(ctrl.ie), .dma_en(ctrl.dma_en),
    .ovf_f(ovf_f), .udf_f(udf_f), .wm_f(wm_f), .ne_f(ne_f), .full_f(full_f),
    .irq(irq), .dma_req(dma_req)
  );

  assign unused_ptr = ^{wr_ptr[PW-1], rd_ptr[PW-1]};

  always_comb begin
    ctrl_word              = '0;
    ctrl_word[B_EN]        = ctrl.conv_en;
    ctrl_word[B_MODE +: 2] = ctrl.mode;
    ctrl_word[B_TSEL]      = ctrl.trig_sw;
    ctrl_word[B_DMA]       = ctrl.dma_en;
    ctrl_word[B_IE +: 4]   = ctrl.ie;
    ctrl_word[B_WM +: WM_W] = ctrl.wm;
    stat_word              = {27'd0, full_f, ne_f, wm_f, udf_f, ovf_f};
    ptr_word               = '0;
    ptr_word[0 +: AW]      = rd_ptr[AW-1:0];
    ptr_word[16 +: AW]     = wr_ptr[AW-1:0];
  end

  always_comb begin
    case (reg_addr)
      ADDR_CTRL: reg_rdata = ctrl_word;
      ADDR_STAT: reg_rdata = stat_word;
      ADDR_PTR:  reg_rdata = ptr_word;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dac_fifo_seq_chk.sv
module dac_fifo_seq_chk
  import dac_fifo_pkg::*;
#(
  parameter int PW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          data_push,
  input logic          is_fifo,
  input logic          full_f,
  input logic          ne_f,
  input logic          ovf_f,
  input logic          udf_f,
  input logic          trig_eff,
  input fifo_mode_e    mode,
  input logic [PW-1:0] occupancy,
  input logic [PW-1:0] wr_ptr,
  input logic [PW-1:0] rd_ptr,
  input logic          irq,
  input logic          dma_req,
  input logic          fifo_rst_cmd,
  input logic          soft_rst_cmd,
  input logic [31:0]   ctrl_word
);
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_push && is_fifo && full_f) |=> ovf_f);

  assert_wr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_push && is_fifo && full_f) |=> $stable(wr_ptr));

  assert_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_eff && mode == MODE_NORMAL && occupancy <= PW'(1)) |=> (udf_f && $stable(rd_ptr)));

  assert_flag_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    full_f |-> !ne_f);

  assert_steer_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq && dma_req));

  assert_ptr_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rst_cmd |=> (occupancy == '0 && rd_ptr == '0));

  assert_soft_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_cmd |=> (ctrl_word == '0 && occupancy == '0 && !ovf_f && !udf_f));
endmodule

bind dac_fifo_seq dac_fifo_seq_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .data_push(data_push), .is_fifo(is_fifo),
  .full_f(full_f), .ne_f(ne_f), .ovf_f(ovf_f), .udf_f(udf_f),
  .trig_eff(trig_eff), .mode(ctrl.mode), .occupancy(occupancy),
  .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .irq(irq), .dma_req(dma_req),
  .fifo_rst_cmd(fifo_rst_cmd), .soft_rst_cmd(soft_rst_cmd), .ctrl_word(ctrl_word)
);

// File: tb/dac_fifo_seq_test.sv
module dac_fifo_seq_test;
  localparam int DW = 12;

  logic          clk;
  logic          rst_n;
  logic          reg_we;
  logic [1:0]    reg_addr;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic          hw_trig;
  logic [DW-1:0] sample_out;
  logic          irq;
  logic          dma_req;

  dac_fifo_seq #(.DEPTH_CODE(2), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_trig(hw_trig),
    .sample_out(sample_out), .irq(irq), .dma_req(dma_req)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    string       tag;
    logic [31:0] exp;
  } item_t;

  item_t       sb_q[$];
  logic [31:0] obs_val;
  event        obs_ev;
  int          n_chk  = 0;
  int          n_fail = 0;
  bit          done   = 1'b0;

  always begin
    @(obs_ev);
    if (sb_q.size() == 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL scoreboard: observation %h with nothing expected", obs_val);
    end else begin
      item_t it;
      it = sb_q.pop_front();
      n_chk++;
      if (obs_val !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, obs_val, it.exp);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we    = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic push_exp(input string tag, input logic [31:0] e);
    item_t it;
    it.tag = tag;
    it.exp = e;
    sb_q.push_back(it);
  endtask

  task automatic chk_reg(input string tag, input logic [1:0] a, input logic [31:0] e);
    idle(2);
    reg_addr = a;
    #1;
    push_exp(tag, e);
    obs_val = reg_rdata;
    ->obs_ev;
    #1;
  endtask

  task automatic chk_out(input string tag, input logic [31:0] e);
    idle(2);
    #1;
    push_exp(tag, e);
    obs_val = 32'(sample_out);
    ->obs_ev;
    #1;
  endtask

  task automatic chk_req(input string tag, input logic [31:0] e);
    idle(2);
    #1;
    push_exp(tag, e);
    obs_val = {30'd0, dma_req, irq};
    ->obs_ev;
    #1;
  endtask

  task automatic hw_pulse(input int hold);
    @(negedge clk);
    hw_trig = 1'b1;
    idle(hold);
    hw_trig = 1'b0;
    idle(4);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    reg_we    = 1'b0;
    reg_addr  = 2'd0;
    reg_wdata = 32'd0;
    hw_trig   = 1'b0;
    idle(4);
    rst_n = 1'b1;

    chk_reg("R1 control after reset", 2'd0, 32'h0);
    chk_reg("R1 status after reset", 2'd1, 32'h0);
    chk_reg("R1 pointers after reset", 2'd3, 32'h0);
    chk_out("R1 sample after reset", 32'h0);
    chk_req("R1 requests after reset", 32'h0);

    // bypass
    wr(2'd0, 32'h1);
    wr(2'd2, 32'h123);
    chk_out("R2 bypass first write", 32'h123);
    wr(2'd2, 32'h456);
    chk_out("R2 bypass replace", 32'h456);
    chk_reg("R2 bypass pointers", 2'd3, 32'h0);
    hw_pulse(3);
    chk_out("R9 trigger in bypass ignored", 32'h456);

    // normal mode, software trigger, watermark 3
    wr(2'd0, 32'h0003_000A);
    wr(2'd2, 32'h10);
    wr(2'd2, 32'h11);
    wr(2'd2, 32'h12);
    chk_reg("R3 write pointer advance", 2'd3, 32'h0003_0000);
    chk_out("R3 head sample", 32'h10);
    chk_reg("R6 three entries no flags", 2'd1, 32'h0);
    wr(2'd0, 32'h0003_001A);
    chk_reg("R9 trigger while disabled ignored", 2'd3, 32'h0003_0000);
    wr(2'd0, 32'h0003_000B);
    wr(2'd0, 32'h0003_001B);
    chk_reg("R3 read pointer advance", 2'd3, 32'h0003_0001);
    chk_out("R3 second sample", 32'h11);
    chk_reg("R6 watermark below level", 2'd1, 32'h4);
    wr(2'd0, 32'h0003_001B);
    chk_out("R3 third sample", 32'h12);
    chk_reg("R6 nearly empty", 2'd1, 32'hC);
    wr(2'd0, 32'h0003_001B);
    chk_reg("R5 underflow flag", 2'd1, 32'hE);
    chk_reg("R5 read pointer held", 2'd3, 32'h0003_0002);
    chk_out("R5 sample held", 32'h12);
    wr(2'd1, 32'h1E);
    chk_reg("R13 clear leaves level flags", 2'd1, 32'hC);
    wr(2'd0, 32'h0003_001B);
    chk_reg("R5 underflow again", 2'd1, 32'hE);
    wr(2'd0, 32'h0003_010B);
    chk_reg("R13 control write keeps flag", 2'd1, 32'hE);
    chk_req("R11 error to interrupt", 32'h1);
    wr(2'd0, 32'h0003_018B);
    chk_req("R11 error to dma", 32'h2);
    wr(2'd1, 32'h2);
    chk_req("R11 no request after clear", 32'h0);
    wr(2'd0, 32'h0003_000B);

    // fill and overflow
    for (int i = 0; i < 7; i++) wr(2'd2, 32'h20 + 32'(i));
    chk_reg("R6 full", 2'd1, 32'h10);
    chk_reg("R3 pointers at full", 2'd3, 32'h0002_0002);
    wr(2'd2, 32'h99);
    chk_reg("R4 overflow flag", 2'd1, 32'h11);
    chk_reg("R4 pointers held", 2'd3, 32'h0002_0002);
    chk_out("R4 sample unchanged", 32'h12);
    wr(2'd0, 32'h0003_080B);
    chk_req("R11 full interrupt", 32'h1);
    wr(2'd0, 32'h0003_000B);
    wr(2'd1, 32'h1);
    chk_reg("R13 overflow cleared", 2'd1, 32'h10);
    wr(2'd0, 32'h0003_001B);
    chk_out("R3 wrapped order", 32'h20);

    // pointer reset
    wr(2'd0, 32'h0003_002B);
    chk_reg("R8 reset ignored while enabled", 2'd3, 32'h0002_0003);
    wr(2'd0, 32'h0003_000A);
    wr(2'd0, 32'h0003_002A);
    chk_reg("R8 reset honoured when disabled", 2'd3, 32'h0);
    chk_reg("R8 empty after reset", 2'd1, 32'h4);

    // hardware trigger
    wr(2'd0, 32'h3);
    wr(2'd2, 32'h30);
    wr(2'd2, 32'h31);
    wr(2'd2, 32'h32);
    hw_pulse(10);
    chk_reg("R10 held level one step", 2'd3, 32'h0003_0001);
    hw_pulse(2);
    chk_reg("R10 second edge", 2'd3, 32'h0003_0002);
    chk_out("R10 sample after edges", 32'h32);
    wr(2'd0, 32'h13);
    chk_reg("R9 software bit ignored on hardware source", 2'd3, 32'h0003_0002);
    chk_reg("R6 one left before collision", 2'd1, 32'h8);

    // underflow event and its clear in the same cycle
    @(negedge clk);
    hw_trig = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    reg_we    = 1'b1;
    reg_addr  = 2'd1;
    reg_wdata = 32'h2;
    @(negedge clk);
    reg_we  = 1'b0;
    hw_trig = 1'b0;
    idle(3);
    chk_reg("R13 set wins over clear", 2'd1, 32'hA);
    chk_reg("R5 pointer held on collision", 2'd3, 32'h0003_0002);
    wr(2'd1, 32'h2);
    chk_reg("R13 underflow cleared", 2'd1, 32'h8);

    // swing
    wr(2'd0, 32'h0);
    wr(2'd0, 32'h20);
    wr(2'd0, 32'hC);
    for (int i = 0; i < 8; i++) wr(2'd2, 32'h40 + 32'(i));
    wr(2'd0, 32'hD);
    chk_out("R7 swing start", 32'h40);
    for (int k = 1; k <= 15; k++) begin
      logic [31:0] e;
      if (k <= 7) e = 32'h40 + 32'(k);
      else if (k <= 14) e = 32'h40 + 32'(14 - k);
      else e = 32'h41;
      wr(2'd0, 32'h1D);
      chk_out("R7 swing step", e);
    end
    chk_reg("R7 no underflow in sweep", 2'd1, 32'h0);
    chk_reg("R7 final pointers", 2'd3, 32'h0000_0001);
    wr(2'd2, 32'h50);
    wr(2'd2, 32'h51);
    chk_reg("R4 overflow in swing", 2'd1, 32'h11);

    // software reset
    wr(2'd0, 32'h0003_0F4D);
    chk_reg("R12 control cleared", 2'd0, 32'h0);
    chk_reg("R12 status cleared", 2'd1, 32'h0);
    chk_reg("R12 pointers cleared", 2'd3, 32'h0);
    chk_out("R12 sample cleared", 32'h0);
    chk_req("R12 requests cleared", 32'h0);

    #5;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule